// File: doc/BRIEF.md
# Delay-Matched Exponent Gain Shifter

This block rebuilds a fixed-point sample from a floating-point pair. The mantissa is the signed sample from a 14-bit converter. The exponent is the attenuation step code issued by an external range controller. Each 6 dB attenuation step is undone by one bit of left shift, so the gain from the antenna to the digital output stays the same whatever attenuation is in force.

An exponent change only reaches the converter output after the attenuator has settled, the filter has passed it and the converter pipeline has moved it through. For that reason the exponent is not applied at once. It passes through a circular buffer whose read tap sits a programmable 1 to 256 clocks behind the write tap. The shifted result and the input valid strobe leave through one output register.

Top module: `expgain_top`

## Requirements
- R1: While reset is held and after it is released, before any clock edge, `out_smp` is 0 and `out_vld` is 0.
- R2: `out_smp` is `in_mant`, read as two's complement and sign-extended to 18 bits, shifted left by the delayed exponent e. The multiplier is 2^e (x1, x2, x4, x8, x16 for e = 0..4) and the sign is kept.
- R3: The data path has exactly one register. The sample taken at clock edge k appears at edge k. `out_vld` at edge k equals `in_vld` at edge k. `out_smp` is updated at every edge, whatever `in_vld` is.
- R4: With `dly_code` = d, the exponent used at edge k is the `in_exp` sampled at edge k − (d + 1), so the delay is N = d + 1 clocks.
- R5: `dly_code` = 255 gives the longest delay, 256 clocks, without aliasing to a shorter one.
- R6: A new `dly_code` applies from the first edge at which it is sampled. The stored exponent history is kept.
- R7: Reset fills the history with exponent 0. Until N edges have passed since reset, the output therefore uses gain x1.
- R8: `in_exp` codes 5, 6 and 7 on the 3-bit field are stored as 4, the largest shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input sample valid |
| in_mant | input | 14 | Converter sample, two's complement |
| in_exp | input | 3 | Attenuation step code from the range controller |
| dly_code | input | 8 | Compensating delay minus one (0..255 gives 1..256 clocks) |
| out_vld | output | 1 | Output sample valid |
| out_smp | output | 18 | Fixed-point sample, two's complement |

## Verification
The bench first targets the delay count. A read tap that is off by one clock, for example one that treats the code as N instead of N − 1, applies the gain one sample early or late. A reference model that indexes a history of the exponents driven then catches the mismatch. Code 255 is exercised for more than 256 clocks, because a pointer subtraction that wraps wrongly would alias it to a delay of zero or one. A delay change in mid-stream checks that the history survives: a design that cleared its buffer would drop to gain x1. The most negative mantissa at the largest shift, together with exponent codes 5 to 7, exposes a shift that is not sign-extended or that overflows.

// File: rtl/expgain_pkg.sv
package expgain_pkg;
   localparam int MANT_W_DEF = 14;
   localparam int EXP_W_DEF  = 3;
   localparam int EXP_MAX_DEF = 4;
   localparam int DEPTH_DEF  = 256;

   function automatic int out_width(input int mant_w, input int exp_max);
      return mant_w + exp_max;
   endfunction
endpackage

// File: rtl/expgain_delay.sv
module expgain_delay #(
   parameter int DEPTH   = expgain_pkg::DEPTH_DEF,
   parameter int EXP_W   = expgain_pkg::EXP_W_DEF,
   parameter int EXP_MAX = expgain_pkg::EXP_MAX_DEF,
   localparam int PTR_W  = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EXP_W-1:0] exp_in,
   input  logic [PTR_W-1:0] dly_code,
   output logic [EXP_W-1:0] exp_out
);
   logic [EXP_W-1:0] hist_q [DEPTH];
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_ptr;
   logic [EXP_W-1:0] exp_lim;
   logic             primed;

   if ((1 << PTR_W) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two");
   end
   if (EXP_MAX >= (1 << EXP_W)) begin : g_bad_exp
      $error("EXP_MAX does not fit in EXP_W bits");
   end

   if (((1 << EXP_W) - 1) > EXP_MAX) begin : g_clamp
      always_comb exp_lim = (exp_in > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : exp_in;
   end else begin : g_pass
      always_comb exp_lim = exp_in;
   end

   // code d means d+1 clocks; wrap of the pointer maps code DEPTH-1 to a full lap
   assign rd_ptr  = PTR_W'(wr_ptr - dly_code - PTR_W'(1));
   assign exp_out = hist_q[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
         wr_ptr <= '0;
         primed <= 1'b0;
      end else begin
         hist_q[wr_ptr] <= exp_lim;
         wr_ptr         <= wr_ptr + PTR_W'(1);
         primed         <= 1'b1;
      end
   end

   // R4
   delay_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && dly_code == '0) |-> (exp_out == $past(exp_lim)));
   // R8
   exp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exp_out <= EXP_W'(EXP_MAX));
endmodule

// File: rtl/expgain_shift.sv
module expgain_shift #(
   parameter int MANT_W  = expgain_pkg::MANT_W_DEF,
   parameter int EXP_W   = expgain_pkg::EXP_W_DEF,
   parameter int EXP_MAX = expgain_pkg::EXP_MAX_DEF,
   localparam int OUT_W  = expgain_pkg::out_width(MANT_W, EXP_MAX)
) (
   input  logic [MANT_W-1:0] mant,
   input  logic [EXP_W-1:0]  expo,
   output logic [OUT_W-1:0]  prod
);
   logic signed [OUT_W-1:0] ext;
   logic signed [OUT_W-1:0] cand [EXP_MAX+1];

   assign ext = OUT_W'($signed(mant));

   for (genvar k = 0; k <= EXP_MAX; k++) begin : g_tap
      assign cand[k] = ext <<< k;
   end

   always_comb begin
      prod = cand[0];
      for (int k = 1; k <= EXP_MAX; k++) begin
         if (expo == EXP_W'(k)) prod = cand[k];
      end
   end
endmodule

// File: rtl/expgain_top.sv
module expgain_top #(
   parameter int MANT_W  = expgain_pkg::MANT_W_DEF,
   parameter int EXP_W   = expgain_pkg::EXP_W_DEF,
   parameter int EXP_MAX = expgain_pkg::EXP_MAX_DEF,
   parameter int DEPTH   = expgain_pkg::DEPTH_DEF,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int OUT_W  = expgain_pkg::out_width(MANT_W, EXP_MAX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic [MANT_W-1:0] in_mant,
   input  logic [EXP_W-1:0]  in_exp,
   input  logic [PTR_W-1:0]  dly_code,
   output logic              out_vld,
   output logic [OUT_W-1:0]  out_smp
);
   logic [EXP_W-1:0] exp_dly;
   logic [OUT_W-1:0] shifted;
   logic             primed;

   if (MANT_W < 2) begin : g_bad_mant
      $error("MANT_W too small");
   end

   expgain_delay #(.DEPTH(DEPTH), .EXP_W(EXP_W), .EXP_MAX(EXP_MAX)) u_dly (
      .clk(clk), .rst_n(rst_n), .exp_in(in_exp), .dly_code(dly_code), .exp_out(exp_dly)
   );

   expgain_shift #(.MANT_W(MANT_W), .EXP_W(EXP_W), .EXP_MAX(EXP_MAX)) u_shf (
      .mant(in_mant), .expo(exp_dly), .prod(shifted)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_smp <= '0;
         out_vld <= 1'b0;
         primed  <= 1'b0;
      end else begin
         out_smp <= shifted;
         out_vld <= in_vld;
         primed  <= 1'b1;
      end
   end

   // R3
   vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> (out_vld == $past(in_vld)));
   // R2
   sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(in_mant) != '0) |-> (out_smp[OUT_W-1] == $past(in_mant[MANT_W-1])));
   // R1
   reset_zero_chk: assert property (@(posedge clk)
      !rst_n |-> (out_smp == '0 && !out_vld));
endmodule

// File: tb/tb_expgain_top.sv
`timescale 1ns/1ps
module tb_expgain_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic [13:0] in_mant = '0;
   logic [2:0]  in_exp = '0;
   logic [7:0]  dly_code = '0;
   logic        out_vld;
   logic [17:0] out_smp;

   int n_chk = 0;
   int n_err = 0;
   int hist [4096];
   int edge_n = 0;

   always #2.5 clk = ~clk;

   expgain_top dut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_mant(in_mant), .in_exp(in_exp),
      .dly_code(dly_code), .out_vld(out_vld), .out_smp(out_smp)
   );

   task automatic check(input string req, input longint act, input longint expv);
      n_chk++;
      if (act != expv) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // one sample: drive at negedge, model the edge, compare at the next negedge
   task automatic step(input bit v, input int m, input int x, input int dc, input string req);
      int xc; int idx; int ee; longint ev;
      in_vld = v; in_mant = 14'(m); in_exp = 3'(x); dly_code = 8'(dc);
      @(posedge clk);
      xc = (x > 4) ? 4 : x;
      hist[edge_n] = xc;
      idx = edge_n - (dc + 1);
      ee = (idx >= 0) ? hist[idx] : 0;
      edge_n++;
      ev = longint'(m) * (longint'(1) << ee);
      @(negedge clk);
      check(req, longint'($signed(out_smp)), ev);
      check(req, longint'(out_vld), longint'(v));
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      in_vld = 1'b1; in_mant = 14'h1abc; in_exp = 3'd3;
      repeat (3) @(negedge clk);
      check("R1", longint'(out_smp), 0);
      check("R1", longint'(out_vld), 0);
      rst_n = 1'b1;
      #1;
      check("R1", longint'(out_smp), 0);
      edge_n = 0;
   endtask

   task automatic t_history_zero;   // R7 then R4 at code 3
      for (int i = 0; i < 8; i++) step(1'b1, 1000, 2, 3, i < 4 ? "R7" : "R4");
   endtask

   task automatic t_gain;           // R2 at delay 1
      for (int i = 0; i < 12; i++) step(1'b1, (i % 2) ? 1234 : -777, i % 5, 0, "R2");
      step(1'b1, -8192, 4, 0, "R2");
      step(1'b1, -8192, 4, 0, "R2");
      step(1'b1, 8191, 4, 0, "R2");
      step(1'b1, -1, 0, 0, "R2");
   endtask

   task automatic t_delay;          // R4 with code 9
      for (int i = 0; i < 40; i++) step(1'b1, 37 * i - 700, (i / 3) % 5, 9, "R4");
   endtask

   task automatic t_max;            // R5
      for (int i = 0; i < 300; i++) step(1'b1, 500 - i, (i / 7) % 5, 255, "R5");
   endtask

   task automatic t_change;         // R6
      for (int i = 0; i < 10; i++) step(1'b1, 300, i % 5, 2, "R6");
      for (int i = 0; i < 12; i++) step(1'b1, -300, (i + 2) % 5, 6, "R6");
      for (int i = 0; i < 6; i++) step(1'b1, 55, 1, 0, "R6");
   endtask

   task automatic t_clamp;          // R8
      for (int i = 0; i < 6; i++) step(1'b1, -4096 + i, 5 + (i % 3), 0, "R8");
   endtask

   task automatic t_valid;          // R3
      for (int i = 0; i < 10; i++) step(i % 3 == 0, 11 * i, i % 4, 1, "R3");
   endtask

   initial begin
      #(5.0 * 150000);
      n_err++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_history_zero();
      t_gain();
      t_delay();
      t_max();
      t_change();
      t_clamp();
      t_valid();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule